// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Chain

This block holds the digital counters of an integer-N frequency synthesizer. A reference divider turns a reference tick stream into a comparison-rate strobe. A dual-modulus feedback divider, made of a 32/33 prescaler counter, a main counter and a swallow counter, divides a VCO tick stream by N = 32*Smc + Ssc. A phase-frequency detector compares the two strobes and produces up and down pulses for an external charge pump. A lock detector watches the width of those pulses.

One registered status pin carries either the lock flag or one of several counter-derived test waveforms. A separate charge-pump output enable is dropped in the test codes that keep the pump quiet. All logic runs on one system clock. The reference edges and the VCO edges arrive as one-cycle strobes, so the block needs no clock-domain crossing. The analog pump, filter and oscillator sit outside.

Top module: `pswallow_synth_div`

## Requirements
- R1: The reference divider emits one comparison strobe every 3, 4, 6 or 8 `ref_pulse` strobes for `cfg_rsel` = 0, 1, 2 or 3. The first strobe follows the first `ref_pulse` after reset.
- R2: The feedback divider emits one strobe every N = 32*(40+`cfg_mc`) + `cfg_sc` `vco_pulse` strobes, so N runs from 1280 to 1535. The first strobe follows the first `vco_pulse` after reset. Each period uses `cfg_sc` prescaler cycles of 33 and (40+`cfg_mc`-`cfg_sc`) cycles of 32.
- R3: A change of `cfg_mc`, `cfg_sc` or `cfg_rsel` is taken only when the running period ends, so the period in progress completes at its old length.
- R4: `pfd_up` rises the cycle after a reference strobe and `pfd_dn` rises the cycle after a feedback strobe. When both are high they are both low on the next cycle.
- R5: With `cfg_test`=0 the status pin goes to 1 after 16 consecutive comparison periods whose count of cycles with exactly one of up/down high is at most `lock_thresh`. It returns to 0 at the first period boundary where that count exceeds the threshold.
- R6: `cfg_test` chooses the status pin source, one cycle later: 0 the lock flag, 1 a square wave toggling on each feedback strobe, 2 one toggling on each reference strobe, 3 one toggling every 256 reference strobes (reference divided by 512), 7 the raw reference strobe.
- R7: `cp_oe` is 1 for `cfg_test` 0 to 3 and 0 for 4 to 7. Codes 4, 5 and 6 route the same source as 0, 1 and 2.
- R8: During reset `pfd_up`, `pfd_dn` and `stat_pin` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock edge |
| vco_pulse | input | 1 | One-cycle strobe per VCO clock edge |
| cfg_rsel | input | 2 | Reference ratio code (3/4/6/8) |
| cfg_mc | input | 3 | Main counter code, Smc = 40 + code |
| cfg_sc | input | 5 | Swallow count Ssc |
| cfg_test | input | 3 | Status pin source and pump-quiet select |
| lock_thresh | input | ERR_W | Allowed phase-error cycles per period |
| pfd_up | output | 1 | Phase detector up pulse |
| pfd_dn | output | 1 | Phase detector down pulse |
| stat_pin | output | 1 | Lock flag or test waveform |
| cp_oe | output | 1 | Charge pump output enable |

## Verification
The feedback divider is tried with divide settings at both ends of the range and with two mid-range settings, each having a different mix of 33- and 32-cycle prescaler cycles. This separates a wrong swallow count from a wrong main count and from an off-by-one at reload. Each reference code is measured on its own. A mid-period change of the divide value shows whether the running period is cut short. The lock test first runs matched reference and feedback rates, which gives coincident up/down pulses and lock after the sixteenth period. It then adds one VCO cycle to N, so the phase error grows by one cycle per period. This shows that lock holds while the error stays under the threshold and drops once it is exceeded.

// File: rtl/pswallow_pkg.sv
`timescale 1ns/1ps
package pswallow_pkg;

    localparam int PRE_LO     = 32;
    localparam int MC_BASE    = 40;
    localparam int MC_CODE_W  = 3;
    localparam int SC_W       = 5;
    localparam int RSEL_W     = 2;
    localparam int TEST_W     = 3;
    localparam int PRE_CNT_W  = $clog2(PRE_LO + 1);
    localparam int MC_CNT_W   = $clog2(MC_BASE + (1 << MC_CODE_W));
    localparam int REF_CNT_W  = 3;

    typedef enum logic [TEST_W-1:0] {
        TST_LOCK     = 3'd0,
        TST_PC_HALF  = 3'd1,
        TST_REF_HALF = 3'd2,
        TST_REF_SLOW = 3'd3,
        TST_LOCK_Q   = 3'd4,
        TST_PC_Q     = 3'd5,
        TST_REF_Q    = 3'd6,
        TST_REF_RAW  = 3'd7
    } test_sel_e;

    typedef struct packed {
        logic [REF_CNT_W-1:0] cnt;
        logic                 tc;
    } ref_st_t;

    typedef struct packed {
        logic [PRE_CNT_W-1:0] pre;
        logic [MC_CNT_W-1:0]  mc;
        logic [SC_W-1:0]      sc;
        logic                 tc;
    } fb_st_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    // last count value of a reference period: ratio minus one
    function automatic logic [REF_CNT_W-1:0] ref_last(input logic [RSEL_W-1:0] sel);
        logic [REF_CNT_W-1:0] r;
        case (sel)
            2'd0:    r = 3'd2;
            2'd1:    r = 3'd3;
            2'd2:    r = 3'd5;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pswallow_ref_div.sv
`timescale 1ns/1ps
module pswallow_ref_div
    import pswallow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic [RSEL_W-1:0] ratio_sel,
    output logic              ref_tc
);

    ref_st_t st_q, st_d;

    // down-counter; ratio sampled only on reload (R1, R3)
    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (ref_pulse) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = ref_last(ratio_sel);
                st_d.tc  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_tc = st_q.tc;

endmodule

// File: rtl/pswallow_fb_div.sv
`timescale 1ns/1ps
module pswallow_fb_div
    import pswallow_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vco_pulse,
    input  logic [MC_CODE_W-1:0] mc_code,
    input  logic [SC_W-1:0]      sc_code,
    output logic                 div_tc
);

    localparam logic [PRE_CNT_W-1:0] PRE_LONG  = PRE_CNT_W'(PRE_LO);
    localparam logic [PRE_CNT_W-1:0] PRE_SHORT = PRE_CNT_W'(PRE_LO - 1);
    localparam logic [MC_CNT_W-1:0]  MC_LOAD   = MC_CNT_W'(MC_BASE - 1);

    fb_st_t          st_q, st_d;
    logic [SC_W-1:0] sc_left;

    // prescaler counts 33 while swallow cycles remain, else 32 (R2)
    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        sc_left = (st_q.sc != '0) ? st_q.sc - 1'b1 : '0;
        if (vco_pulse) begin
            if (st_q.pre == '0) begin
                if (st_q.mc == '0) begin
                    // output period ends: take new settings (R3)
                    st_d.mc  = MC_LOAD + MC_CNT_W'(mc_code);
                    st_d.sc  = sc_code;
                    st_d.pre = (sc_code != '0) ? PRE_LONG : PRE_SHORT;
                    st_d.tc  = 1'b1;
                end else begin
                    st_d.mc  = st_q.mc - 1'b1;
                    st_d.sc  = sc_left;
                    st_d.pre = (sc_left != '0) ? PRE_LONG : PRE_SHORT;
                end
            end else begin
                st_d.pre = st_q.pre - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_tc = st_q.tc;

endmodule

// File: rtl/pswallow_pfd.sv
`timescale 1ns/1ps
module pswallow_pfd
    import pswallow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tc,
    input  logic div_tc,
    output logic pfd_up,
    output logic pfd_dn
);

    pfd_st_t st_q, st_d;
    logic    both;

    // R4: set on own strobe, both cleared one cycle after overlap
    always_comb begin
        both    = st_q.up & st_q.dn;
        st_d.up = both ? 1'b0 : (st_q.up | ref_tc);
        st_d.dn = both ? 1'b0 : (st_q.dn | div_tc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pfd_up = st_q.up;
    assign pfd_dn = st_q.dn;

endmodule

// File: rtl/pswallow_lock_det.sv
`timescale 1ns/1ps
module pswallow_lock_det #(
    parameter int ERR_W    = 8,
    parameter int LOCK_RUN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_tc,
    input  logic             up,
    input  logic             dn,
    input  logic [ERR_W-1:0] thresh,
    output logic             locked
);

    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);
    localparam logic [ERR_W-1:0] ERR_MAX  = '1;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [RUN_W-1:0] run;
        logic             locked;
    } ld_st_t;

    ld_st_t st_q, st_d;

    // R5: per-period error width against threshold, 16-period run to lock
    always_comb begin
        st_d = st_q;
        if (period_tc) begin
            st_d.err = '0;
            if (st_q.err <= thresh) begin
                if (st_q.run != RUN_FULL) begin
                    st_d.run = st_q.run + 1'b1;
                end
                st_d.locked = (st_q.run + 1'b1 >= RUN_FULL);
            end else begin
                st_d.run    = '0;
                st_d.locked = 1'b0;
            end
        end else if ((up ^ dn) && (st_q.err != ERR_MAX)) begin
            st_d.err = st_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

endmodule

// File: rtl/pswallow_synth_div.sv
`timescale 1ns/1ps
module pswallow_synth_div
    import pswallow_pkg::*;
#(
    parameter int ERR_W    = 8,
    parameter int LOCK_RUN = 16,
    parameter int SLOW_DIV = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_pulse,
    input  logic                 vco_pulse,
    input  logic [RSEL_W-1:0]    cfg_rsel,
    input  logic [MC_CODE_W-1:0] cfg_mc,
    input  logic [SC_W-1:0]      cfg_sc,
    input  logic [TEST_W-1:0]    cfg_test,
    input  logic [ERR_W-1:0]     lock_thresh,
    output logic                 pfd_up,
    output logic                 pfd_dn,
    output logic                 stat_pin,
    output logic                 cp_oe
);

    localparam int SLOW_W = $clog2(SLOW_DIV / 2);
    localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV / 2 - 1);

    typedef struct packed {
        logic              pc_half;
        logic              ref_half;
        logic [SLOW_W-1:0] slow_cnt;
        logic              slow_half;
        logic              pin;
    } mux_st_t;

    logic      ref_tc;
    logic      div_tc;
    logic      lock_flag;
    test_sel_e tsel;
    mux_st_t   mx_q, mx_d;

    pswallow_ref_div ref_div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .ratio_sel (cfg_rsel),
        .ref_tc    (ref_tc)
    );

    pswallow_fb_div fb_div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vco_pulse (vco_pulse),
        .mc_code   (cfg_mc),
        .sc_code   (cfg_sc),
        .div_tc    (div_tc)
    );

    pswallow_pfd pfd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_tc (ref_tc),
        .div_tc (div_tc),
        .pfd_up (pfd_up),
        .pfd_dn (pfd_dn)
    );

    pswallow_lock_det #(
        .ERR_W    (ERR_W),
        .LOCK_RUN (LOCK_RUN)
    ) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_tc (ref_tc),
        .up        (pfd_up),
        .dn        (pfd_dn),
        .thresh    (lock_thresh),
        .locked    (lock_flag)
    );

    assign tsel = test_sel_e'(cfg_test);

    // R6, R7: halved and slow waveforms plus registered pin select
    always_comb begin
        mx_d = mx_q;
        if (div_tc) begin
            mx_d.pc_half = ~mx_q.pc_half;
        end
        if (ref_tc) begin
            mx_d.ref_half = ~mx_q.ref_half;
            if (mx_q.slow_cnt == SLOW_LAST) begin
                mx_d.slow_cnt  = '0;
                mx_d.slow_half = ~mx_q.slow_half;
            end else begin
                mx_d.slow_cnt = mx_q.slow_cnt + 1'b1;
            end
        end
        case (tsel)
            TST_LOCK, TST_LOCK_Q:        mx_d.pin = lock_flag;
            TST_PC_HALF, TST_PC_Q:       mx_d.pin = mx_q.pc_half;
            TST_REF_HALF, TST_REF_Q:     mx_d.pin = mx_q.ref_half;
            TST_REF_SLOW:                mx_d.pin = mx_q.slow_half;
            default:                     mx_d.pin = ref_tc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mx_q <= '0;
        end else begin
            mx_q <= mx_d;
        end
    end

    assign stat_pin = mx_q.pin;
    assign cp_oe    = ~cfg_test[TEST_W-1];

endmodule

// File: rtl/pswallow_synth_div_chk.sv
`timescale 1ns/1ps
module pswallow_synth_div_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_pulse,
    input logic       vco_pulse,
    input logic       ref_tc,
    input logic       div_tc,
    input logic       pfd_up,
    input logic       pfd_dn,
    input logic       lock_flag,
    input logic [2:0] cfg_test,
    input logic       stat_pin
);

    a_r1_ref_tc_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tc |-> $past(ref_pulse));

    a_r2_div_tc_from_vco: assert property (@(posedge clk) disable iff (!rst_n)
        div_tc |-> $past(vco_pulse));

    a_r4_up_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfd_up) |-> $past(ref_tc));

    a_r4_dn_after_div: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfd_dn) |-> $past(div_tc));

    a_r4_overlap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_up && pfd_dn) |=> (!pfd_up && !pfd_dn));

    a_r5_lock_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(ref_tc));

    a_r5_lock_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_flag) |-> $past(ref_tc));

    a_r6_lock_route: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_test) == 3'd0) |-> (stat_pin == $past(lock_flag)));

endmodule

bind pswallow_synth_div pswallow_synth_div_chk chk_i (.*);

// File: tb/pswallow_synth_div_tb_top.sv
`timescale 1ns/1ps
module pswallow_synth_div_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0;
    logic       vco_pulse = 1'b0;
    logic [1:0] cfg_rsel = '0;
    logic [2:0] cfg_mc = '0;
    logic [4:0] cfg_sc = '0;
    logic [2:0] cfg_test = '0;
    logic [7:0] lock_thresh = 8'd4;
    logic       pfd_up, pfd_dn, stat_pin, cp_oe;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    bit  gen_on = 0;
    bit  vco_on = 1;
    int  ref_k = 7;
    int  phase = 0;

    localparam int NV = 4;
    localparam int VEC_MC [NV] = '{0, 7, 3, 5};
    localparam int VEC_SC [NV] = '{0, 31, 17, 9};
    localparam int VEC_N  [NV] = '{1280, 1535, 1393, 1449};

    always #2.5 clk = ~clk;

    pswallow_synth_div dut_i (.*);

    // tick generator: reference and VCO strobes start together
    always @(negedge clk) begin
        if (!gen_on) begin
            phase = 0;
            ref_pulse <= 1'b0;
            vco_pulse <= 1'b0;
        end else begin
            ref_pulse <= ((phase % ref_k) == 0);
            vco_pulse <= vco_on;
            phase++;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        gen_on = 0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reset pfd_up", pfd_up, 0);
        chk("R8 reset pfd_dn", pfd_dn, 0);
        chk("R8 reset stat_pin", stat_pin, 0);
        rst_n  = 1'b1;
        gen_on = 1;
    endtask

    task automatic wait_edge(output int cyc);
        logic prev;
        prev = stat_pin;
        cyc  = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (stat_pin == prev && cyc < 5000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        int iv;
        int hi;
        // R2: vector table of divide settings, pin in feedback/2 mode
        for (int v = 0; v < NV; v++) begin
            cfg_test = 3'd1;
            cfg_mc   = 3'(VEC_MC[v]);
            cfg_sc   = 5'(VEC_SC[v]);
            ref_k    = 7;
            do_reset();
            wait_edge(iv);
            wait_edge(iv);
            chk($sformatf("R2 divide N vec%0d", v), iv, VEC_N[v]);
            chk("R7 cp_oe in code 1", cp_oe, 1);
        end

        // R1: reference ratios, pin in reference/2 mode
        for (int s = 0; s < 4; s++) begin
            cfg_test = 3'd2;
            cfg_rsel = 2'(s);
            ref_k    = 1;
            do_reset();
            wait_edge(iv);
            wait_edge(iv);
            chk($sformatf("R1 ref ratio code %0d", s), iv, (s == 0) ? 3 : (s == 1) ? 4 : (s == 2) ? 6 : 8);
        end

        // R6: reference divided by 512
        cfg_test = 3'd3; cfg_rsel = 2'd0; ref_k = 1;
        do_reset();
        wait_edge(iv);
        wait_edge(iv);
        chk("R6 slow toggle interval", iv, 768);

        // R6, R7: raw reference strobe with pump quiet
        cfg_test = 3'd7; cfg_rsel = 2'd1; ref_k = 1;
        do_reset();
        repeat (20) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            hi += int'(stat_pin);
        end
        chk("R6 raw strobe high count", hi, 10);
        chk("R7 cp_oe code 7", cp_oe, 0);

        // R7: code 5 routes feedback/2, code 6 reference/2, pump quiet
        cfg_test = 3'd5; cfg_mc = 3'd0; cfg_sc = 5'd0; ref_k = 7;
        do_reset();
        wait_edge(iv);
        wait_edge(iv);
        chk("R7 code 5 routes feedback half", iv, 1280);
        chk("R7 cp_oe code 5", cp_oe, 0);
        cfg_test = 3'd6; cfg_rsel = 2'd2; ref_k = 1;
        do_reset();
        wait_edge(iv);
        wait_edge(iv);
        chk("R7 code 6 routes reference half", iv, 6);
        chk("R7 cp_oe code 6", cp_oe, 0);

        // R3: mid-period change completes the running period
        cfg_test = 3'd1; cfg_mc = 3'd0; cfg_sc = 5'd0; ref_k = 7;
        do_reset();
        wait_edge(iv);
        wait_edge(iv);
        repeat (100) @(negedge clk);
        cfg_mc = 3'd1;
        wait_edge(iv);
        chk("R3 running period keeps old N", iv + 100, 1280);
        wait_edge(iv);
        chk("R3 next period uses new N", iv, 1312);

        // R5, R4: matched rates lock, then one-cycle-per-period drift
        cfg_test = 3'd0; cfg_rsel = 2'd0; cfg_mc = 3'd0; cfg_sc = 5'd1;
        lock_thresh = 8'd4; ref_k = 427;
        do_reset();
        repeat (13 * 1281 + 600) @(negedge clk);
        chk("R5 not locked before 16 periods", stat_pin, 0);
        repeat (4 * 1281) @(negedge clk);
        chk("R5 locked after 16 good periods", stat_pin, 1);
        chk("R7 cp_oe code 0", cp_oe, 1);
        iv = 0;
        while (!pfd_up && iv < 3000) begin
            @(negedge clk);
            iv++;
        end
        chk("R4 aligned up with dn", pfd_dn, 1);
        @(negedge clk);
        chk("R4 overlap clears up", pfd_up, 0);
        chk("R4 overlap clears dn", pfd_dn, 0);
        cfg_sc = 5'd2;
        repeat (3 * 1281) @(negedge clk);
        chk("R5 lock holds under threshold", stat_pin, 1);
        repeat (10 * 1281) @(negedge clk);
        chk("R5 lock drops past threshold", stat_pin, 0);
        iv = 0;
        while (!pfd_up && iv < 3000) begin
            @(negedge clk);
            iv++;
        end
        chk("R4 up leads lagging dn", pfd_dn, 0);

        finish_run();
    end

    initial begin
        #(5.0 * 180000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule